// File: doc/BRIEF.md
# Reduced-ISA Instruction Execute Unit

This block is a purely combinational execute stage for a small integer subset of a 32-bit load-store RISC instruction set. It receives one instruction word together with the values already read for its two source registers. From these it produces the value to write back, the index of the register that receives it, and a write strobe.

The unit decodes the instruction fields itself. It recognises the register-register form, where opcode 0 selects the operation through a function code. It also recognises the register-immediate form, where the opcode selects the operation and a 16-bit constant stands in for the second operand. The extension rule for that constant, and the choice of destination field, depend on the instruction.

Any encoding outside the supported set raises an illegal-instruction flag and suppresses the write. A surrounding pipeline places the register file in front of this stage and write-back after it.

Top module: `risc_exec_unit`

## Requirements
- R1: Instruction bits 31:26 are the opcode. For opcode 0, bits 25:21 name the first source, bits 20:16 the second source, bits 15:11 the destination, bits 10:6 the shift amount and bits 5:0 the function code. Function code 0x20 (add) writes rs_val + rt_val to the register named in bits 15:11.
- R2: Function code 0x22 (subtract) writes rs_val - rt_val. Both add and subtract wrap modulo 2^32 and raise no exception.
- R3: Function codes 0x24, 0x25 and 0x27 write rs_val AND rt_val, rs_val OR rt_val and NOT(rs_val OR rt_val) respectively.
- R4: Function codes 0x00 and 0x02 shift rt_val left and right by the shift amount in bits 10:6 (0 to 31). Vacated bits fill with zeros, and rs_val has no effect.
- R5: Opcode 0x08 writes rs_val plus the 16-bit constant in bits 15:0. The constant is sign-extended by replicating bit 15. The destination is the field in bits 20:16, and rt_val has no effect.
- R6: Opcode 0x0A writes 1 when rs_val is less than the sign-extended constant, both taken as signed numbers, and writes 0 otherwise. The destination is bits 20:16.
- R7: Opcodes 0x0C and 0x0D write rs_val AND, and rs_val OR, the zero-extended constant. The destination is bits 20:16.
- R8: Opcode 0x0F writes the constant into result bits 31:16 with bits 15:0 zero. Neither source value has an effect.
- R9: Any other opcode, or opcode 0 with any other function code, sets illegal_o and clears wr_en_o, with result_o and dest_idx_o both zero.
- R10: Every supported instruction drives illegal_o low and wr_en_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to execute |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Write-back value |
| dest_idx_o | output | 5 | Index of the destination register |
| wr_en_o | output | 1 | Write strobe for the destination register |
| illegal_o | output | 1 | Unsupported encoding detected |

## Verification
The bench builds the unit with its default 32-bit data width. At that width the field positions, the 5-bit shift amount and the 16-bit constant all sit exactly where the encodings place them. This makes reachable the extreme shift amounts 0 and 31, and wrap-around at the full 2^32 boundary. It also covers the constant's sign bit, where signed and unsigned comparison disagree.

// File: rtl/exec_pkg.sv
// Package exec_pkg
// Shared widths, encodings and the internal operation type of the execute unit.
// Assumes the fixed 32-bit instruction layout; data width follows XLEN.
package exec_pkg;
    localparam int XLEN     = 32;
    localparam int ILEN     = 32;
    localparam int REG_W    = 5;
    localparam int SHAMT_W  = $clog2(XLEN);
    localparam int IMM_W    = 16;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_LUI  = 6'h0F;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
        ALU_SLL, ALU_SRL, ALU_SLT, ALU_LUI, ALU_NONE
    } alu_op_e;
endpackage

// File: rtl/exec_decode.sv
// Module exec_decode
// Splits an instruction into its fields and picks the operation, the second
// operand source, the extended constant and the destination index.
// Assumes opcode in bits 31:26; purely combinational.
module exec_decode
    import exec_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic [ILEN-1:0]    instr_i,
    output alu_op_e            op_o,
    output logic               use_imm_o,
    output logic [DW-1:0]      imm_o,
    output logic [REG_W-1:0]   dest_o,
    output logic [SHAMT_W-1:0] shamt_o,
    output logic               illegal_o
);
    localparam int EXT_W = DW - IMM_W;

    logic [5:0]       opc;
    logic [5:0]       fn;
    logic [IMM_W-1:0] imm16;
    logic [DW-1:0]    imm_sext;
    logic [DW-1:0]    imm_zext;

    assign opc      = instr_i[31:26];
    assign fn       = instr_i[5:0];
    assign imm16    = instr_i[15:0];
    assign shamt_o  = instr_i[6 +: SHAMT_W];
    assign imm_sext = {{EXT_W{imm16[IMM_W-1]}}, imm16};
    assign imm_zext = {{EXT_W{1'b0}}, imm16};

    // Choose operation, constant form and destination from opcode and function code.
    always_comb begin
        op_o      = ALU_NONE;
        use_imm_o = 1'b0;
        imm_o     = imm_zext;
        dest_o    = instr_i[20:16];
        illegal_o = 1'b0;
        if (opc == OPC_REG) begin
            dest_o = instr_i[15:11];
            case (fn)
                FN_ADD:  op_o = ALU_ADD;
                FN_SUB:  op_o = ALU_SUB;
                FN_AND:  op_o = ALU_AND;
                FN_OR:   op_o = ALU_OR;
                FN_NOR:  op_o = ALU_NOR;
                FN_SLL:  op_o = ALU_SLL;
                FN_SRL:  op_o = ALU_SRL;
                default: illegal_o = 1'b1;
            endcase
        end else begin
            use_imm_o = 1'b1;
            case (opc)
                OPC_ADDI: begin op_o = ALU_ADD; imm_o = imm_sext; end
                OPC_SLTI: begin op_o = ALU_SLT; imm_o = imm_sext; end
                OPC_ANDI: op_o = ALU_AND;
                OPC_ORI:  op_o = ALU_OR;
                OPC_LUI:  op_o = ALU_LUI;
                default:  illegal_o = 1'b1;
            endcase
        end
    end

    // Immediate checks on the extension rules.
    always_comb begin
        if (!$isunknown(instr_i)) begin
            // R7
            zext_upper_chk: assert (!((opc == OPC_ANDI) || (opc == OPC_ORI))
                                    || (imm_o[DW-1:IMM_W] == '0));
            // R5
            sext_upper_chk: assert (!(opc == OPC_ADDI)
                                    || (imm_o[DW-1:IMM_W] == {EXT_W{instr_i[15]}}));
        end
    end
endmodule

// File: rtl/exec_alu.sv
// Module exec_alu
// Computes the result for one decoded operation on two operands.
// Assumes the second operand is already the register value or the extended constant.
module exec_alu
    import exec_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  alu_op_e            op_i,
    input  logic [DW-1:0]      a_i,
    input  logic [DW-1:0]      b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [DW-1:0]      res_o
);
    // Evaluate the selected operation; unsupported operations yield zero.
    always_comb begin
        case (op_i)
            ALU_ADD: res_o = a_i + b_i;
            ALU_SUB: res_o = a_i - b_i;
            ALU_AND: res_o = a_i & b_i;
            ALU_OR:  res_o = a_i | b_i;
            ALU_NOR: res_o = ~(a_i | b_i);
            ALU_SLL: res_o = b_i << shamt_i;
            ALU_SRL: res_o = b_i >> shamt_i;
            ALU_SLT: res_o = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            ALU_LUI: res_o = {b_i[IMM_W-1:0], {IMM_W{1'b0}}};
            default: res_o = '0;
        endcase
    end

    logic [DW-1:0] low_mask;
    assign low_mask = (DW'(1) << shamt_i) - DW'(1);

    // Immediate checks on result shape per operation.
    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, shamt_i})) begin
            // R6
            slt_range_chk: assert (op_i != ALU_SLT || res_o[DW-1:1] == '0);
            // R8
            lui_low_chk: assert (op_i != ALU_LUI || res_o[IMM_W-1:0] == '0);
            // R4
            sll_fill_chk: assert (op_i != ALU_SLL || (res_o & low_mask) == '0);
            // R4
            srl_fill_chk: assert (op_i != ALU_SRL
                                  || ({<<{res_o}} & low_mask) == '0);
        end
    end
endmodule

// File: rtl/risc_exec_unit.sv
// Module risc_exec_unit
// Combinational execute stage: decode, operand select, compute, write-back control.
// Assumes register values are read ahead of this stage; no clock or state inside.
module risc_exec_unit
    import exec_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] result_o,
    output logic [4:0]  dest_idx_o,
    output logic        wr_en_o,
    output logic        illegal_o
);
    alu_op_e            op;
    logic               use_imm;
    logic [XLEN-1:0]    imm;
    logic [REG_W-1:0]   dest;
    logic [SHAMT_W-1:0] shamt;
    logic               bad;
    logic [XLEN-1:0]    opnd_b;
    logic [XLEN-1:0]    alu_res;

    exec_decode #(.DW(XLEN)) u_dec (
        .instr_i   (instr_i),
        .op_o      (op),
        .use_imm_o (use_imm),
        .imm_o     (imm),
        .dest_o    (dest),
        .shamt_o   (shamt),
        .illegal_o (bad)
    );

    // Second operand is the constant for register-immediate forms.
    assign opnd_b = use_imm ? imm : rt_val_i;

    exec_alu #(.DW(XLEN)) u_alu (
        .op_i    (op),
        .a_i     (rs_val_i),
        .b_i     (opnd_b),
        .shamt_i (shamt),
        .res_o   (alu_res)
    );

    // Quiet all write-back outputs on an unsupported encoding.
    always_comb begin
        illegal_o  = bad;
        wr_en_o    = ~bad;
        result_o   = bad ? '0 : alu_res;
        dest_idx_o = bad ? '0 : dest;
    end

    // Cross-module check between decoder and ALU.
    always_comb begin
        if (!$isunknown({instr_i, rs_val_i, rt_val_i})) begin
            // R9
            illegal_quiet_chk: assert (!bad || (op == ALU_NONE && alu_res == '0));
        end
    end
endmodule

// File: tb/risc_exec_unit_tb.sv
module risc_exec_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] instr, rs_val, rt_val, result;
    logic [4:0]  dest;
    logic        wr_en, illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    risc_exec_unit u_dut (
        .instr_i(instr), .rs_val_i(rs_val), .rt_val_i(rt_val),
        .result_o(result), .dest_idx_o(dest), .wr_en_o(wr_en), .illegal_o(illegal)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [4:0] sh,
                                          input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] opc, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {opc, rs, rt, imm};
    endfunction

    // {instr, rs_val, rt_val, result, dest, wr_en, illegal}
    localparam int NV = 22;
    localparam logic [134:0] VEC [0:NV-1] = '{
        {enc_r(5'd1,5'd2,5'd3,5'd0,6'h20), 32'd5, 32'd7, 32'd12, 5'd3, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd4,5'd0,6'h20), 32'hFFFFFFFF, 32'd2, 32'd1, 5'd4, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd5,5'd0,6'h22), 32'd3, 32'd5, 32'hFFFFFFFE, 5'd5, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd9,5'd0,6'h22), 32'h80000000, 32'd1, 32'h7FFFFFFF, 5'd9, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd10,5'd0,6'h24), 32'hF0F000FF, 32'h0FF00F0F, 32'h00F0000F, 5'd10, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd11,5'd0,6'h25), 32'hF0F000FF, 32'h0FF00F0F, 32'hFFF00FFF, 5'd11, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd12,5'd0,6'h27), 32'hF0F000FF, 32'h0FF00F0F, 32'h000FF000, 5'd12, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd6,5'd31,6'h00), 32'hFFFFFFFF, 32'h00000001, 32'h80000000, 5'd6, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd6,5'd31,6'h02), 32'hFFFFFFFF, 32'h80000000, 32'h00000001, 5'd6, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd13,5'd0,6'h02), 32'h12345678, 32'hDEADBEEF, 32'hDEADBEEF, 5'd13, 1'b1, 1'b0},
        {enc_r(5'd1,5'd2,5'd14,5'd4,6'h00), 32'h0, 32'h8000000F, 32'h000000F0, 5'd14, 1'b1, 1'b0},
        {enc_i(6'h08,5'd1,5'd7,16'hFFFF), 32'd10, 32'hFFFFFFFF, 32'd9, 5'd7, 1'b1, 1'b0},
        {enc_i(6'h08,5'd1,5'd8,16'h8000), 32'd0, 32'h12345678, 32'hFFFF8000, 5'd8, 1'b1, 1'b0},
        {enc_i(6'h0A,5'd1,5'd15,16'h0001), 32'hFFFFFFFE, 32'd0, 32'd1, 5'd15, 1'b1, 1'b0},
        {enc_i(6'h0A,5'd1,5'd16,16'hFFFF), 32'd5, 32'd0, 32'd0, 5'd16, 1'b1, 1'b0},
        {enc_i(6'h0A,5'd1,5'd17,16'h0007), 32'd7, 32'd0, 32'd0, 5'd17, 1'b1, 1'b0},
        {enc_i(6'h0C,5'd1,5'd18,16'h8001), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00008001, 5'd18, 1'b1, 1'b0},
        {enc_i(6'h0D,5'd1,5'd19,16'h8000), 32'h12340000, 32'hFFFFFFFF, 32'h12348000, 5'd19, 1'b1, 1'b0},
        {enc_i(6'h0F,5'd1,5'd20,16'hABCD), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hABCD0000, 5'd20, 1'b1, 1'b0},
        {enc_i(6'h3F,5'd1,5'd21,16'h1234), 32'd1, 32'd2, 32'd0, 5'd0, 1'b0, 1'b1},
        {enc_r(5'd1,5'd2,5'd22,5'd0,6'h21), 32'd1, 32'd2, 32'd0, 5'd0, 1'b0, 1'b1},
        {enc_i(6'h23,5'd1,5'd23,16'h0004), 32'd1, 32'd2, 32'd0, 5'd0, 1'b0, 1'b1}
    };

    function automatic string tag_of(input int i);
        if (i < 1)  return "R1";
        if (i < 4)  return "R2";
        if (i < 7)  return "R3";
        if (i < 11) return "R4";
        if (i < 13) return "R5";
        if (i < 16) return "R6";
        if (i < 18) return "R7";
        if (i < 19) return "R8";
        return "R9";
    endfunction

    task automatic check_out(input string tag, input logic [31:0] er,
                             input logic [4:0] ed, input logic ew, input logic ei);
        checks++;
        if (result !== er || dest !== ed || wr_en !== ew || illegal !== ei) begin
            fails++;
            $display("FAIL %s instr=%h got res=%h dest=%0d we=%b ill=%b exp res=%h dest=%0d we=%b ill=%b",
                     tag, instr, result, dest, wr_en, illegal, er, ed, ew, ei);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr = ins; rs_val = a; rt_val = b;
        #1;
    endtask

    initial begin
        instr = '0; rs_val = '0; rt_val = '0;
        repeat (3) @(posedge clk);
        // R10: reset-time word 0 is a shift of zero by zero into index 0, legal
        @(negedge clk); #1;
        check_out("R10", 32'd0, 5'd0, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][134:103], VEC[i][102:71], VEC[i][70:39]);
            check_out(tag_of(i), VEC[i][38:7], VEC[i][6:2], VEC[i][1], VEC[i][0]);
        end

        // R3: nor of two zeros gives all ones
        apply(enc_r(5'd0, 5'd0, 5'd25, 5'd0, 6'h27), 32'd0, 32'd0);
        check_out("R3", 32'hFFFFFFFF, 5'd25, 1'b1, 1'b0);
        // R4: rs value does not reach a left shift
        apply(enc_r(5'd3, 5'd4, 5'd26, 5'd1, 6'h00), 32'hAAAA5555, 32'h00000003);
        check_out("R4", 32'h00000006, 5'd26, 1'b1, 1'b0);
        // R8: lui ignores both sources, zero constant
        apply(enc_i(6'h0F, 5'd2, 5'd27, 16'h0000), 32'h13579BDF, 32'h2468ACE0);
        check_out("R8", 32'h00000000, 5'd27, 1'b1, 1'b0);
        // R6: most negative register below any constant
        apply(enc_i(6'h0A, 5'd2, 5'd28, 16'h8000), 32'h80000000, 32'd0);
        check_out("R6", 32'd1, 5'd28, 1'b1, 1'b0);
        // R9: funct 0x03 under opcode 0 is unsupported
        apply(enc_r(5'd1, 5'd2, 5'd29, 5'd3, 6'h03), 32'd9, 32'd9);
        check_out("R9", 32'd0, 5'd0, 1'b0, 1'b1);
        // R1: destination 31 with add
        apply(enc_r(5'd1, 5'd2, 5'd31, 5'd0, 6'h20), 32'h7FFFFFFF, 32'd1);
        check_out("R1", 32'h80000000, 5'd31, 1'b1, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule